// File: doc/BRIEF.md
# Decode-Stage Issue Interlock

This block decides, every cycle, whether the instruction in the decode stage of an in-order pipeline may move on into execute. The pipeline has execution units with different result latencies: integer ALU, load, FP add class and FP multiply class. The block keeps a short history of recently issued instructions, recording each one's class and destination register and how many cycles ago it issued. It compares that history with the sources and the destination of the decoded instruction.

When a read-after-write distance is not yet met, when an older write to the same register is still outstanding, or when the new result would arrive at the single register-file write port in the same cycle as an older one, the block raises `stall`. While `stall` is high, fetch and decode hold their contents, and the execute stage receives a bubble because `iss_valid` is low. The history keeps ageing during stalls.

Branches have exactly one delay slot. The instruction that issues after a branch is marked on `iss_dslot` and is always issued, whatever the branch outcome. Forwarding paths, exceptions and the units themselves are outside this block.

Top module: `issue_interlock`

## Requirements
- R1: A consumer of any kind that reads the destination of a load is held for exactly one bubble when it directly follows the load.
- R2: Against an FP add-class producer, an ordinary consumer waits three bubbles. A store waits only two when the register is its data operand. The store's address is source A and its data is source B.
- R3: Against an FP multiply-class producer, an ordinary consumer waits five bubbles and a store-data consumer waits four.
- R4: An integer ALU result feeds the next ordinary instruction with no bubble. A branch reading it waits one bubble.
- R5: An instruction that writes a register an older in-flight instruction also writes waits until that older one has reached write-back. Write-back comes 3 cycles after issue for integer and load, 6 for FP add and 8 for FP multiply.
- R6: An instruction whose write-back would fall in the same cycle as the write-back of an older instruction is held in decode, with at most one register write per cycle.
- R7: The instruction issued next after a branch, including after stall or idle cycles, is issued, never squashed, and has `iss_dslot` high. Every other issued instruction has `iss_dslot` low.
- R8: Integer register 0 neither creates nor receives a dependence and is never a write target.
- R9: Integer and FP registers with the same index are distinct and never interact.
- R10: `stall` is a combinational function of the decode inputs and the history. `iss_valid` is high exactly when `dec_valid` is high and `stall` is low. With `dec_valid` low there is no stall. After reset the history is empty. `dec_op` codes: 0 NOP, 1 integer ALU, 2 load, 3 FP add, 4 FP multiply, 5 store, 6 branch.
- R11: Loops in steady state take the following numbers of cycles per iteration:
  - load/FP-add/store/decrement/branch/NOP: 10 cycles.
  - the same loop reordered, with the store in the delay slot: 6 cycles.
  - the multiply version with two pointer decrements: 12 cycles.
  - the multiply version reordered: 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_op | input | 3 | Instruction class code (see R10) |
| dec_dst_fp | input | 1 | Destination is in the FP register file |
| dec_dst_idx | input | 5 | Destination register index |
| dec_a_use | input | 1 | Source A is read |
| dec_a_fp | input | 1 | Source A is an FP register |
| dec_a_idx | input | 5 | Source A index (store address) |
| dec_b_use | input | 1 | Source B is read |
| dec_b_fp | input | 1 | Source B is an FP register |
| dec_b_idx | input | 5 | Source B index (store data) |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| iss_valid | output | 1 | Decoded instruction enters execute this cycle |
| iss_dslot | output | 1 | Issuing instruction occupies the branch delay slot |

## Verification
The assertions assume that the decode inputs stay low for `dec_valid` during reset. They also assume that an instruction, once presented, is held unchanged until it issues, as a real decode register would hold it under `stall`. The bench drives each instruction on the falling edge and changes it only after it has sampled `iss_valid` high. Idle cycles are inserted with `dec_valid` low. Random operands are drawn from a small register set in both namespaces, with store data and branch operands placed on the source lanes that R2 and R4 define, so that every producer/consumer distance and every write-port coincidence occurs often.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  localparam int IDX_W = 5;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_INT    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_FADD   = 3'd3,
    OP_FMUL   = 3'd4,
    OP_STORE  = 3'd5,
    OP_BRANCH = 3'd6
  } op_e;

  // How a source operand is consumed; selects the required distance.
  typedef enum logic [1:0] {
    USE_PLAIN  = 2'd0,
    USE_STDATA = 2'd1,
    USE_BRANCH = 2'd2
  } use_e;

  typedef struct packed {
    logic             fp;
    logic [IDX_W-1:0] idx;
  } reg_t;

  typedef struct packed {
    logic vld;
    op_e  op;
    logic wr;
    reg_t dst;
  } slot_t;

  function automatic logic op_writes(op_e op);
    return (op == OP_INT) || (op == OP_LOAD) || (op == OP_FADD) || (op == OP_FMUL);
  endfunction

  // Integer register 0 is hard-wired and never tracked.
  function automatic logic reg_live(reg_t r);
    return r.fp || (r.idx != '0);
  endfunction

endpackage

// File: rtl/ilk_tracker.sv
module ilk_tracker
  import ilk_pkg::*;
#(
  parameter int DEPTH = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_vld,
  input  op_e                    push_op,
  input  logic                   push_wr,
  input  reg_t                   push_dst,
  output slot_t [DEPTH-1:0]      slots
);

  // Slot k holds the instruction issued k+1 cycles ago; a bubble enters
  // slot 0 on a stall, so every entry ages each cycle.
  slot_t head;

  always_comb begin
    head     = '0;
    head.vld = push_vld;
    head.op  = push_op;
    head.wr  = push_vld && push_wr;
    head.dst = push_dst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots <= '0;
    end else begin
      slots <= {slots[DEPTH-2:0], head};
    end
  end

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int DEPTH    = 7,
  parameter int LAT_INT  = 1,
  parameter int LAT_LD   = 2,
  parameter int LAT_FADD = 4,
  parameter int LAT_FMUL = 6,
  parameter int BR_EXTRA = 1,
  parameter int ST_EARLY = 1,
  parameter int WB_TAIL  = 2
) (
  input  slot_t [DEPTH-1:0] slots,
  input  logic              a_live,
  input  reg_t              a_reg,
  input  use_e              a_kind,
  input  logic              b_live,
  input  reg_t              b_reg,
  input  use_e              b_kind,
  input  logic              d_wr,
  input  op_e               d_op,
  input  reg_t              d_dst,
  output logic              raw_hit,
  output logic              waw_hit,
  output logic              port_hit
);

  function automatic int lat_of(op_e op);
    case (op)
      OP_INT:  return LAT_INT;
      OP_LOAD: return LAT_LD;
      OP_FADD: return LAT_FADD;
      OP_FMUL: return LAT_FMUL;
      default: return 0;
    endcase
  endfunction

  // Cycles from issue to register write; the load latency already covers
  // the memory stage, so it passes one stage fewer on the way to write-back.
  function automatic int wb_of(op_e op);
    case (op)
      OP_INT:  return LAT_INT + WB_TAIL;
      OP_LOAD: return LAT_LD + WB_TAIL - 1;
      OP_FADD: return LAT_FADD + WB_TAIL;
      OP_FMUL: return LAT_FMUL + WB_TAIL;
      default: return 0;
    endcase
  endfunction

  // Bubbles a consumer of kind u needs right behind producer p.
  function automatic int bubbles(op_e p, use_e u);
    int b;
    b = lat_of(p) - 1;
    if (u == USE_STDATA && (p == OP_FADD || p == OP_FMUL)) b = b - ST_EARLY;
    if (u == USE_BRANCH && p == OP_INT) b = b + BR_EXTRA;
    if (b < 0) b = 0;
    return b;
  endfunction

  logic [DEPTH-1:0] raw_v;
  logic [DEPTH-1:0] waw_v;
  logic [DEPTH-1:0] port_v;
  int               d_w;

  assign d_w = wb_of(d_op);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    slot_t s;
    int    pw;
    int    ba;
    int    bb;
    logic  prod;

    assign s    = slots[k];
    assign prod = s.vld && s.wr;
    assign pw   = wb_of(s.op);
    assign ba   = bubbles(s.op, a_kind);
    assign bb   = bubbles(s.op, b_kind);

    assign raw_v[k]  = prod && ((a_live && (a_reg == s.dst) && (k < ba)) ||
                                (b_live && (b_reg == s.dst) && (k < bb)));
    assign waw_v[k]  = prod && d_wr && (d_dst == s.dst) && (k < pw - 1);
    assign port_v[k] = prod && d_wr && (d_w == pw - 1 - k);
  end

  assign raw_hit  = |raw_v;
  assign waw_hit  = |waw_v;
  assign port_hit = |port_v;

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int LAT_INT  = 1,
  parameter int LAT_LD   = 2,
  parameter int LAT_FADD = 4,
  parameter int LAT_FMUL = 6,
  parameter int BR_EXTRA = 1,
  parameter int ST_EARLY = 1,
  parameter int WB_TAIL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [OP_W-1:0]  dec_op,
  input  logic             dec_dst_fp,
  input  logic [IDX_W-1:0] dec_dst_idx,
  input  logic             dec_a_use,
  input  logic             dec_a_fp,
  input  logic [IDX_W-1:0] dec_a_idx,
  input  logic             dec_b_use,
  input  logic             dec_b_fp,
  input  logic [IDX_W-1:0] dec_b_idx,
  output logic             stall,
  output logic             iss_valid,
  output logic             iss_dslot
);

  localparam int WB_INT  = LAT_INT + WB_TAIL;
  localparam int WB_LD   = LAT_LD + WB_TAIL - 1;
  localparam int WB_FADD = LAT_FADD + WB_TAIL;
  localparam int WB_FMUL = LAT_FMUL + WB_TAIL;
  localparam int WB_M1   = (WB_INT > WB_LD) ? WB_INT : WB_LD;
  localparam int WB_M2   = (WB_FADD > WB_FMUL) ? WB_FADD : WB_FMUL;
  localparam int WB_MAX  = (WB_M1 > WB_M2) ? WB_M1 : WB_M2;
  localparam int DEPTH   = (WB_MAX > 2) ? WB_MAX - 1 : 2;

  op_e   d_op;
  reg_t  d_dst;
  reg_t  a_reg;
  reg_t  b_reg;
  logic  d_wr;
  logic  a_live;
  logic  b_live;
  use_e  a_kind;
  use_e  b_kind;
  logic  raw_hit;
  logic  waw_hit;
  logic  port_hit;
  logic  br_pend;
  slot_t [DEPTH-1:0] slot_q;

  assign d_op   = op_e'(dec_op);
  assign d_dst  = {dec_dst_fp, dec_dst_idx};
  assign a_reg  = {dec_a_fp, dec_a_idx};
  assign b_reg  = {dec_b_fp, dec_b_idx};
  assign d_wr   = dec_valid && op_writes(d_op) && reg_live(d_dst);
  assign a_live = dec_valid && dec_a_use && reg_live(a_reg);
  assign b_live = dec_valid && dec_b_use && reg_live(b_reg);

  // Branch operands meet the branch distance; a store's B lane carries data.
  assign a_kind = (d_op == OP_BRANCH) ? USE_BRANCH : USE_PLAIN;
  assign b_kind = (d_op == OP_BRANCH) ? USE_BRANCH :
                  (d_op == OP_STORE)  ? USE_STDATA : USE_PLAIN;

  ilk_tracker #(
    .DEPTH (DEPTH)
  ) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_vld (iss_valid),
    .push_op  (d_op),
    .push_wr  (d_wr),
    .push_dst (d_dst),
    .slots    (slot_q)
  );

  ilk_hazard #(
    .DEPTH    (DEPTH),
    .LAT_INT  (LAT_INT),
    .LAT_LD   (LAT_LD),
    .LAT_FADD (LAT_FADD),
    .LAT_FMUL (LAT_FMUL),
    .BR_EXTRA (BR_EXTRA),
    .ST_EARLY (ST_EARLY),
    .WB_TAIL  (WB_TAIL)
  ) u_hz (
    .slots    (slot_q),
    .a_live   (a_live),
    .a_reg    (a_reg),
    .a_kind   (a_kind),
    .b_live   (b_live),
    .b_reg    (b_reg),
    .b_kind   (b_kind),
    .d_wr     (d_wr),
    .d_op     (d_op),
    .d_dst    (d_dst),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit),
    .port_hit (port_hit)
  );

  assign stall     = raw_hit || waw_hit || port_hit;
  assign iss_valid = dec_valid && !stall;

  // Remembers that the last issued instruction was a branch until the
  // next issue, which is the delay slot and is never squashed.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_pend <= 1'b0;
    end else if (iss_valid) begin
      br_pend <= (d_op == OP_BRANCH);
    end
  end

  assign iss_dslot = iss_valid && br_pend;

endmodule

// File: rtl/ilk_chk.sv
module ilk_chk
  import ilk_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic dec_valid,
  input op_e  op,
  input logic a_live,
  input reg_t a_reg,
  input logic b_live,
  input reg_t b_reg,
  input logic iss_wr,
  input reg_t iss_dst,
  input logic iss_valid,
  input logic iss_dslot,
  input logic stall
);

  // R1
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_wr && op == OP_LOAD) && dec_valid &&
     ((a_live && a_reg == $past(iss_dst)) || (b_live && b_reg == $past(iss_dst))))
    |-> stall);

  // R2
  fadd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_wr && op == OP_FADD, 2) && dec_valid &&
     op == OP_STORE && b_live && b_reg == $past(iss_dst, 2))
    |-> stall);

  // R3
  fmul_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_wr && op == OP_FMUL, 4) && dec_valid &&
     op == OP_STORE && b_live && b_reg == $past(iss_dst, 4))
    |-> stall);

  // R4
  int_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iss_valid && iss_wr && op == OP_INT) && dec_valid && op == OP_BRANCH &&
     ((a_live && a_reg == $past(iss_dst)) || (b_live && b_reg == $past(iss_dst))))
    |-> stall);

  // R7
  dslot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid && op == OP_BRANCH)) |-> iss_dslot);

  // R7
  dslot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid && op != OP_BRANCH)) |-> !iss_dslot);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && !iss_valid && !iss_dslot));

endmodule

bind issue_interlock ilk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .op        (d_op),
  .a_live    (a_live),
  .a_reg     (a_reg),
  .b_live    (b_live),
  .b_reg     (b_reg),
  .iss_wr    (d_wr),
  .iss_dst   (d_dst),
  .iss_valid (iss_valid),
  .iss_dslot (iss_dslot),
  .stall     (stall)
);

// File: tb/sim_issue_interlock.sv
module sim_issue_interlock;

  localparam logic [2:0] C_NOP = 3'd0, C_INT = 3'd1, C_LD = 3'd2, C_FA = 3'd3,
                         C_FM = 3'd4, C_ST = 3'd5, C_BR = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic [2:0] dec_op = '0;
  logic       dec_dst_fp = 1'b0;
  logic [4:0] dec_dst_idx = '0;
  logic       dec_a_use = 1'b0;
  logic       dec_a_fp = 1'b0;
  logic [4:0] dec_a_idx = '0;
  logic       dec_b_use = 1'b0;
  logic       dec_b_fp = 1'b0;
  logic [4:0] dec_b_idx = '0;
  logic       stall;
  logic       iss_valid;
  logic       iss_dslot;

  always #4 clk = ~clk;

  issue_interlock u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_dst_fp(dec_dst_fp), .dec_dst_idx(dec_dst_idx),
    .dec_a_use(dec_a_use), .dec_a_fp(dec_a_fp), .dec_a_idx(dec_a_idx),
    .dec_b_use(dec_b_use), .dec_b_fp(dec_b_fp), .dec_b_idx(dec_b_idx),
    .stall(stall), .iss_valid(iss_valid), .iss_dslot(iss_dslot)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;

  int         h_t   [1024];
  logic [2:0] h_op  [1024];
  logic       h_wr  [1024];
  logic [5:0] h_dst [1024];
  int         hn = 0;
  logic       last_br = 1'b0;

  function automatic logic [5:0] ir(int n); return {1'b0, n[4:0]}; endfunction
  function automatic logic [5:0] fr(int n); return {1'b1, n[4:0]}; endfunction

  // Required bubbles: kind 0 ordinary, 1 store data, 2 branch operand.
  function automatic int bub_ref(logic [2:0] op, int kind);
    case (op)
      C_LD:    return 1;
      C_FA:    return (kind == 1) ? 2 : 3;
      C_FM:    return (kind == 1) ? 4 : 5;
      C_INT:   return (kind == 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int wb_ref(logic [2:0] op);
    case (op)
      C_INT, C_LD: return 3;
      C_FA:        return 6;
      C_FM:        return 8;
      default:     return 0;
    endcase
  endfunction

  function automatic logic wr_ref(logic [2:0] op, logic [5:0] dst);
    return (op == C_INT || op == C_LD || op == C_FA || op == C_FM) && (dst != 6'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      dec_valid = 1'b0;
    end
  endtask

  // Present one instruction, wait for it to issue, compare its issue cycle
  // with the earliest cycle that satisfies every timing rule.
  task automatic send(input logic [2:0] op, input logic [5:0] dst,
                      input bit au, input logic [5:0] a,
                      input bit bu, input logic [5:0] b, input string req);
    int  t_app;
    int  exp_t;
    int  waited;
    int  ka;
    int  kb;
    bit  dw;
    bit  ok;
    @(negedge clk);
    dec_valid = 1'b1; dec_op = op;
    dec_dst_fp = dst[5]; dec_dst_idx = dst[4:0];
    dec_a_use = au; dec_a_fp = a[5]; dec_a_idx = a[4:0];
    dec_b_use = bu; dec_b_fp = b[5]; dec_b_idx = b[4:0];
    t_app = cyc;
    dw = wr_ref(op, dst);
    ka = (op == C_BR) ? 2 : 0;
    kb = (op == C_BR) ? 2 : (op == C_ST) ? 1 : 0;
    exp_t = t_app;
    while (exp_t < t_app + 40) begin
      ok = 1'b1;
      for (int j = (hn > 16 ? hn - 16 : 0); j < hn; j++) begin
        if (h_wr[j]) begin
          if (au && a != 6'd0 && a == h_dst[j] && exp_t < h_t[j] + 1 + bub_ref(h_op[j], ka)) ok = 1'b0;
          if (bu && b != 6'd0 && b == h_dst[j] && exp_t < h_t[j] + 1 + bub_ref(h_op[j], kb)) ok = 1'b0;
          if (dw && dst == h_dst[j] && exp_t < h_t[j] + wb_ref(h_op[j])) ok = 1'b0;
          if (dw && exp_t == h_t[j] + wb_ref(h_op[j]) - wb_ref(op)) ok = 1'b0;
        end
      end
      if (ok) break;
      exp_t++;
    end
    waited = 0;
    #1;
    while (stall && waited < 100) begin
      @(negedge clk);
      #1;
      waited++;
    end
    chk(iss_valid && cyc == exp_t, req, cyc, exp_t);
    chk(iss_dslot == last_br, "R7", int'(iss_dslot), int'(last_br));
    h_t[hn] = cyc; h_op[hn] = op; h_wr[hn] = dw; h_dst[hn] = dst;
    hn++;
    last_br = (op == C_BR);
  endtask

  // kind 0: add loop plain, 1: add loop reordered, 2: mul loop plain, 3: mul reordered
  task automatic loop_iter(input int kind);
    case (kind)
      0: begin
        send(C_LD,  fr(0), 1, ir(1), 0, 0,     "R11");
        send(C_FA,  fr(4), 1, fr(0), 1, fr(2), "R11");
        send(C_ST,  0,     1, ir(1), 1, fr(4), "R11");
        send(C_INT, ir(1), 1, ir(1), 0, 0,     "R11");
        send(C_BR,  0,     1, ir(1), 1, ir(2), "R11");
        send(C_NOP, 0,     0, 0,     0, 0,     "R11");
      end
      1: begin
        send(C_LD,  fr(0), 1, ir(1), 0, 0,     "R11");
        send(C_INT, ir(1), 1, ir(1), 0, 0,     "R11");
        send(C_FA,  fr(4), 1, fr(0), 1, fr(2), "R11");
        send(C_BR,  0,     1, ir(1), 1, ir(2), "R11");
        send(C_ST,  0,     1, ir(1), 1, fr(4), "R11");
      end
      2: begin
        send(C_LD,  fr(0), 1, ir(1), 0, 0,     "R11");
        send(C_FM,  fr(4), 1, fr(0), 1, fr(2), "R11");
        send(C_ST,  0,     1, ir(2), 1, fr(4), "R11");
        send(C_INT, ir(1), 1, ir(1), 0, 0,     "R11");
        send(C_INT, ir(2), 1, ir(2), 0, 0,     "R11");
        send(C_BR,  0,     1, ir(1), 1, ir(3), "R11");
        send(C_NOP, 0,     0, 0,     0, 0,     "R11");
      end
      default: begin
        send(C_LD,  fr(0), 1, ir(1), 0, 0,     "R11");
        send(C_INT, ir(1), 1, ir(1), 0, 0,     "R11");
        send(C_FM,  fr(4), 1, fr(0), 1, fr(2), "R11");
        send(C_INT, ir(2), 1, ir(2), 0, 0,     "R11");
        send(C_BR,  0,     1, ir(1), 1, ir(3), "R11");
        send(C_ST,  0,     1, ir(2), 1, fr(4), "R11");
      end
    endcase
  endtask

  task automatic run_loop(input int kind, input int period);
    int s2;
    int s3;
    idle(12);
    loop_iter(kind);
    loop_iter(kind);
    s2 = h_t[hn];
    s2 = cyc;
    loop_iter(kind);
    s3 = hn;
    loop_iter(kind);
    chk(h_t[s3] - h_t[s3 - (kind == 0 || kind == 2 ? (kind == 0 ? 6 : 7) : (kind == 1 ? 5 : 6))] == period,
        "R11", h_t[s3] - h_t[s3 - (kind == 0 ? 6 : kind == 1 ? 5 : kind == 2 ? 7 : 6)], period);
    if (s2 < 0) $display("unreachable");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: empty after reset, no stall with no instruction
    chk(!stall && !iss_valid && !iss_dslot, "R10", int'(stall), 0);
    idle(2);
    #1;
    chk(!stall && !iss_valid, "R10", int'(stall), 0);

    // R1: load then dependent FP add, and dependent branch on integer load
    send(C_LD, fr(1), 1, ir(5), 0, 0, "R1");
    send(C_FA, fr(3), 1, fr(1), 0, 0, "R1");
    idle(10);
    send(C_LD, ir(6), 1, ir(5), 0, 0, "R1");
    send(C_BR, 0,     1, ir(6), 0, 0, "R1");
    send(C_NOP, 0, 0, 0, 0, 0, "R7");

    // R2: FP add feeding store data, then ordinary consumer
    idle(10);
    send(C_FA, fr(4), 0, 0, 0, 0, "R2");
    send(C_ST, 0, 1, ir(7), 1, fr(4), "R2");
    idle(10);
    send(C_FA, fr(6), 0, 0, 0, 0, "R2");
    send(C_FA, fr(7), 1, fr(6), 0, 0, "R2");

    // R3: FP multiply feeding store data, then ordinary consumer
    idle(12);
    send(C_FM, fr(8), 0, 0, 0, 0, "R3");
    send(C_ST, 0, 1, ir(7), 1, fr(8), "R3");
    idle(12);
    send(C_FM, fr(9), 0, 0, 0, 0, "R3");
    send(C_FA, fr(10), 0, 0, 1, fr(9), "R3");

    // R4: integer result to next ALU op (no bubble) and to a branch
    idle(12);
    send(C_INT, ir(3), 1, ir(4), 0, 0, "R4");
    send(C_INT, ir(4), 1, ir(3), 0, 0, "R4");
    send(C_BR,  0,     1, ir(4), 0, 0, "R4");
    send(C_INT, ir(9), 0, 0, 0, 0, "R7");

    // R5: write-after-write behind a long multiply
    idle(12);
    send(C_FM, fr(5), 0, 0, 0, 0, "R5");
    send(C_LD, fr(5), 1, ir(8), 0, 0, "R5");

    // R6: third integer op would collide with the FP add write-back
    idle(12);
    send(C_FA,  fr(11), 0, 0, 0, 0, "R6");
    send(C_INT, ir(10), 0, 0, 0, 0, "R6");
    send(C_INT, ir(11), 0, 0, 0, 0, "R6");
    send(C_INT, ir(12), 0, 0, 0, 0, "R6");

    // R7: delay slot held by a hazard is still issued and marked
    idle(12);
    send(C_FM, fr(12), 0, 0, 0, 0, "R7");
    send(C_BR, 0, 1, ir(1), 1, ir(2), "R7");
    idle(2);
    send(C_FA, fr(13), 1, fr(12), 0, 0, "R7");

    // R8: integer register 0 carries no dependence
    idle(12);
    send(C_LD,  ir(0), 1, ir(5), 0, 0, "R8");
    send(C_INT, ir(0), 1, ir(0), 1, ir(0), "R8");

    // R9: same index in the other file is independent
    idle(12);
    send(C_LD,  fr(2), 1, ir(5), 0, 0, "R9");
    send(C_INT, ir(13), 1, ir(2), 0, 0, "R9");

    // R11: loop schedules
    run_loop(0, 10);
    run_loop(1, 6);
    run_loop(2, 12);
    run_loop(3, 8);

    // Random traffic on a small register set
    idle(12);
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      int ra;
      int rb;
      int rd;
      op = 3'($urandom_range(0, 6));
      ra = $urandom_range(0, 3);
      rb = $urandom_range(0, 3);
      rd = $urandom_range(0, 3);
      case (op)
        C_INT: send(op, ir(rd), 1, ir(ra), $urandom_range(0, 1) == 1, ir(rb), "R4");
        C_LD:  send(op, ($urandom_range(0, 1) == 1) ? fr(rd) : ir(rd), 1, ir(ra), 0, 0, "R1");
        C_FA:  send(op, fr(rd), 1, fr(ra), 1, fr(rb), "R2");
        C_FM:  send(op, fr(rd), 1, fr(ra), 1, fr(rb), "R3");
        C_ST:  send(op, 0, 1, ir(ra), 1, ($urandom_range(0, 1) == 1) ? fr(rb) : ir(rb), "R2");
        C_BR:  send(op, 0, 1, ir(ra), 1, ir(rb), "R4");
        default: send(C_NOP, 0, 0, 0, 0, 0, "R10");
      endcase
      if ($urandom_range(0, 7) == 0) idle(1);
    end

    idle(2);
    #1;
    chk(!stall && !iss_valid, "R10", int'(iss_valid), 0);
    summary();
    $finish;
  end

endmodule